// File: doc/BRIEF.md
# Statically Scheduled Mesh Tile Switch

This block is the network-facing side of one tile in a mesh of processing tiles. Four directional links (north, south, east, west) and the local core meet in a five-output crossbar. Routing is decided entirely at compile time. A small instruction store holds one crossbar setting per schedule slot, and a program counter steps through the slots one per clock. The switch reads no headers and never arbitrates. A single setting may copy one source to several outputs in the same cycle.

Words the core sends into the network wait in a two-entry buffer until a scheduled slot takes them out. Every output, including the one that delivers words to the core, is registered, so each hop through the switch costs exactly one cycle. The schedule is loaded through a write port while the sequencer is halted, and it repeats after a programmable last slot.

The sequencer has two states. HALT is the reset state: the crossbar is idle, the program counter is held at slot 0, and schedule writes are accepted. START is the transition HALT to RUN, taken when `sched_run` is high. In RUN the slot addressed by the program counter drives the crossbar and the counter advances every cycle. STOP is the transition RUN to HALT, taken when `sched_run` is low.

Top module: `tile_sched_xbar`

## Requirements
- R1: During and straight after reset, all five outputs are invalid with zero data, `core_tx_full` is low, the sequencer is in HALT and every schedule slot is all-idle.
- R2: A slot word holds one 3-bit source field per output. The field for output k sits at bits [3k+2:3k], where k is 0 north, 1 south, 2 east, 3 west, 4 core. Codes 1, 2, 3 and 4 select the north, south, east and west input, and code 5 selects the core buffer head. Codes 0, 6 and 7 make the output invalid with zero data.
- R3: A word and its valid bit on a selected link input appear on the output one clock edge later. An invalid input gives an invalid output.
- R4: Several outputs may name the same source in one slot, and each of them then carries that source's word.
- R5: In RUN the program counter advances by one slot per cycle and returns to slot 0 after the slot numbered `sched_last`, so the schedule repeats.
- R6: In HALT all outputs go invalid on the next edge. START always begins at slot 0.
- R7: A schedule write takes effect only if the sequencer is in HALT at that edge. A write made in RUN leaves the stored slot unchanged.
- R8: The core buffer keeps up to two words in arrival order, and `core_tx_full` is high while it holds two. A push made while it is full is dropped.
- R9: In a slot where any output selects code 5, one word leaves the buffer, and it goes to every output that selects code 5. If the buffer is empty at that edge, those outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_in | input | 4*DW | Neighbour input words, index 0 N, 1 S, 2 E, 3 W |
| link_in_vld | input | 4 | Valid bit per neighbour input |
| link_out | output | 4*DW | Registered neighbour output words |
| link_out_vld | output | 4 | Valid bit per neighbour output |
| core_tx_data | input | DW | Word from core into the switch buffer |
| core_tx_push | input | 1 | Push `core_tx_data` into the buffer |
| core_tx_full | output | 1 | Buffer holds two words |
| core_rx_data | output | DW | Registered word delivered to the core |
| core_rx_vld | output | 1 | Valid bit for `core_rx_data` |
| sched_run | input | 1 | High: run the schedule; low: halt |
| sched_last | input | PCW | Index of the last slot before wrap |
| cfg_we | input | 1 | Schedule slot write strobe |
| cfg_addr | input | PCW | Slot index to write |
| cfg_instr | input | 15 | Slot word (five 3-bit source fields) |

## Verification
The properties assume that `sched_last` changes only while the sequencer is halted. They also assume that the core never relies on a push made while `core_tx_full` is high. The stimulus changes `sched_last` only between runs and deliberately pushes into a full buffer once, to check that the word is dropped. It also writes a slot during a run, to check that the write is ignored. The link inputs are sampled every cycle without handshake, so the bench varies their valid bits freely.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
    localparam int NUM_LINKS = 4;
    localparam int NUM_OUTS  = 5;
    localparam int SEL_W     = 3;
    localparam int INSTR_W   = NUM_OUTS * SEL_W;

    typedef enum logic [2:0] {
        SRC_IDLE  = 3'd0,
        SRC_NORTH = 3'd1,
        SRC_SOUTH = 3'd2,
        SRC_EAST  = 3'd3,
        SRC_WEST  = 3'd4,
        SRC_CORE  = 3'd5
    } src_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/tsx_sequencer.sv
module tsx_sequencer
    import tsx_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int PCW   = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PCW-1:0]     last_slot,
    input  logic               wr_en,
    input  logic [PCW-1:0]     wr_addr,
    input  logic [INSTR_W-1:0] wr_instr,
    output logic               running,
    output logic [INSTR_W-1:0] instr
);
    seq_state_e                     state, state_nx;
    logic [PCW-1:0]                 pc;
    logic [SLOTS-1:0][INSTR_W-1:0]  mem;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // transitions START and STOP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (run)  state_nx = ST_RUN;
            ST_RUN:  if (!run) state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    // program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            unique case (state)
                ST_HALT: pc <= '0;
                ST_RUN:  pc <= (!run || pc == last_slot) ? '0 : pc + 1'b1;
                default: pc <= '0;
            endcase
        end
    end

    // schedule store, writable only while halted
    always_ff @(posedge clk) begin
        if (!rst_n)                         mem <= '0;
        else if (wr_en && state == ST_HALT) mem[wr_addr] <= wr_instr;
    end

    // outputs
    always_comb begin
        running = (state == ST_RUN);
        instr   = running ? mem[pc] : '0;
    end

    a_r5_pc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run && pc == last_slot) |=> (pc == '0));
    a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run && pc != last_slot) |=> (pc == $past(pc) + 1'b1));
    a_r6_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (pc == '0));
    a_r7_mem_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(mem));
endmodule

// File: rtl/tsx_core_buf.sv
module tsx_core_buf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          head_vld,
    output logic          full
);
    logic [DW-1:0] ent0, ent1, ent0_nx, ent1_nx;
    logic [1:0]    cnt, cnt_nx, widx;
    logic          pop_ok, push_ok;

    always_comb begin
        pop_ok  = pop  && (cnt != 2'd0);
        push_ok = push && (cnt != 2'd2);
        cnt_nx  = cnt + {1'b0, push_ok} - {1'b0, pop_ok};
        widx    = cnt - {1'b0, pop_ok};
        ent0_nx = pop_ok ? ent1 : ent0;
        ent1_nx = ent1;
        if (push_ok) begin
            if (widx == 2'd0) ent0_nx = push_data;
            else              ent1_nx = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            ent0 <= '0;
            ent1 <= '0;
        end else begin
            cnt  <= cnt_nx;
            ent0 <= ent0_nx;
            ent1 <= ent1_nx;
        end
    end

    assign head_data = ent0;
    assign head_vld  = (cnt != 2'd0);
    assign full      = (cnt == 2'd2);

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/tsx_out_lane.sv
module tsx_out_lane
    import tsx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              sel,
    input  logic [NUM_LINKS-1:0][DW-1:0]  link_data,
    input  logic [NUM_LINKS-1:0]          link_vld,
    input  logic [DW-1:0]                 core_data,
    input  logic                          core_vld,
    output logic [DW-1:0]                 q,
    output logic                          q_vld
);
    logic [DW-1:0] d;
    logic          v;

    always_comb begin
        d = '0;
        v = 1'b0;
        case (src_e'(sel))
            SRC_NORTH: begin d = link_data[0]; v = link_vld[0]; end
            SRC_SOUTH: begin d = link_data[1]; v = link_vld[1]; end
            SRC_EAST:  begin d = link_data[2]; v = link_vld[2]; end
            SRC_WEST:  begin d = link_data[3]; v = link_vld[3]; end
            SRC_CORE:  begin d = core_data;    v = core_vld;    end
            default:   begin d = '0;           v = 1'b0;        end
        endcase
        if (!v) d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q_vld <= 1'b0;
        end else begin
            q     <= d;
            q_vld <= v;
        end
    end
endmodule

// File: rtl/tile_sched_xbar.sv
module tile_sched_xbar
    import tsx_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SLOTS = 16,
    parameter int PCW   = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINKS-1:0][DW-1:0] link_in,
    input  logic [NUM_LINKS-1:0]         link_in_vld,
    output logic [NUM_LINKS-1:0][DW-1:0] link_out,
    output logic [NUM_LINKS-1:0]         link_out_vld,
    input  logic [DW-1:0]                core_tx_data,
    input  logic                         core_tx_push,
    output logic                         core_tx_full,
    output logic [DW-1:0]                core_rx_data,
    output logic                         core_rx_vld,
    input  logic                         sched_run,
    input  logic [PCW-1:0]               sched_last,
    input  logic                         cfg_we,
    input  logic [PCW-1:0]               cfg_addr,
    input  logic [INSTR_W-1:0]           cfg_instr
);
    logic                         running;
    logic [INSTR_W-1:0]           instr;
    logic [NUM_OUTS-1:0]          want_core;
    logic                         core_pop;
    logic [DW-1:0]                buf_data;
    logic                         buf_vld;
    logic [NUM_OUTS-1:0][DW-1:0]  lane_q;
    logic [NUM_OUTS-1:0]          lane_vld;

    tsx_sequencer #(.SLOTS(SLOTS), .PCW(PCW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sched_run),
        .last_slot(sched_last),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_instr (cfg_instr),
        .running  (running),
        .instr    (instr)
    );

    assign core_pop = |want_core;

    tsx_core_buf #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (core_tx_push),
        .push_data(core_tx_data),
        .pop      (core_pop),
        .head_data(buf_data),
        .head_vld (buf_vld),
        .full     (core_tx_full)
    );

    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_lane
        assign want_core[k] = (instr[k*SEL_W +: SEL_W] == SRC_CORE);

        tsx_out_lane #(.DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (instr[k*SEL_W +: SEL_W]),
            .link_data(link_in),
            .link_vld (link_in_vld),
            .core_data(buf_data),
            .core_vld (buf_vld),
            .q        (lane_q[k]),
            .q_vld    (lane_vld[k])
        );

        if (k < NUM_LINKS) begin : g_link
            assign link_out[k]     = lane_q[k];
            assign link_out_vld[k] = lane_vld[k];
        end else begin : g_core
            assign core_rx_data = lane_q[k];
            assign core_rx_vld  = lane_vld[k];
        end

        for (genvar j = 0; j < NUM_LINKS; j++) begin : g_src
            a_r3_hop_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (instr[k*SEL_W +: SEL_W] == 3'(j + 1) && link_in_vld[j])
                |=> (lane_vld[k] && lane_q[k] == $past(link_in[j])));
        end

        a_r9_empty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            (want_core[k] && !buf_vld) |=> !lane_vld[k]);
    end

    a_r6_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (lane_vld == '0));
endmodule

// File: tb/tile_sched_xbar_bench.sv
module tile_sched_xbar_bench;
    localparam int DW = 16;
    localparam int PCW = 4;
    localparam logic [2:0] X_I = 3'd0, X_N = 3'd1, X_S = 3'd2, X_E = 3'd3,
                           X_W = 3'd4, X_C = 3'd5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [3:0][DW-1:0] link_in;
    logic [3:0]       link_in_vld;
    logic [3:0][DW-1:0] link_out;
    logic [3:0]       link_out_vld;
    logic [DW-1:0]    core_tx_data, core_rx_data;
    logic             core_tx_push, core_tx_full, core_rx_vld;
    logic             sched_run, cfg_we;
    logic [PCW-1:0]   sched_last, cfg_addr;
    logic [14:0]      cfg_instr;

    always #2.5 clk = ~clk;

    tile_sched_xbar #(.DW(DW), .SLOTS(16), .PCW(PCW)) u_tile_sched_xbar (
        .clk(clk), .rst_n(rst_n),
        .link_in(link_in), .link_in_vld(link_in_vld),
        .link_out(link_out), .link_out_vld(link_out_vld),
        .core_tx_data(core_tx_data), .core_tx_push(core_tx_push),
        .core_tx_full(core_tx_full),
        .core_rx_data(core_rx_data), .core_rx_vld(core_rx_vld),
        .sched_run(sched_run), .sched_last(sched_last),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_instr(cfg_instr)
    );

    typedef struct {
        logic [4:0]         vld;
        logic [4:0][DW-1:0] dat;
        string              tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] mq[$];
    logic [14:0]   sched [16];
    bit            m_run = 1'b0;
    int            m_pc = 0;
    int            cyc = 0;
    int            tests = 0;
    int            fails = 0;
    bit            done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic logic [14:0] mk(input logic [2:0] n, s, e, w, c);
        return {c, w, e, s, n};
    endfunction

    // driver: drives one cycle of stimulus and pushes the expected outputs
    task automatic step(input logic run, input logic [3:0] iv, input logic push,
                        input logic [DW-1:0] pd, input logic we,
                        input logic [3:0] wa, input logic [14:0] wd,
                        input string tag);
        exp_t        e;
        logic [14:0] ins;
        logic [2:0]  sel;
        bit          popreq, head_ok;
        logic [DW-1:0] head;
        int          size_before;
        @(negedge clk);
        for (int j = 0; j < 4; j++) link_in[j] = DW'(16'h1000 * (j + 1) + cyc);
        link_in_vld  = iv;
        sched_run    = run;
        core_tx_push = push;
        core_tx_data = pd;
        cfg_we       = we;
        cfg_addr     = wa;
        cfg_instr    = wd;
        ins     = m_run ? sched[m_pc] : 15'd0;
        popreq  = 1'b0;
        head_ok = (mq.size() > 0);
        head    = head_ok ? mq[0] : '0;
        e.tag   = tag;
        for (int k = 0; k < 5; k++) begin
            sel = ins[k*3 +: 3];
            e.vld[k] = 1'b0;
            e.dat[k] = '0;
            if (sel >= 3'd1 && sel <= 3'd4) begin
                e.vld[k] = iv[sel - 1];
                e.dat[k] = iv[sel - 1] ? link_in[sel - 1] : '0;
            end else if (sel == 3'd5) begin
                popreq   = 1'b1;
                e.vld[k] = head_ok;
                e.dat[k] = head;
            end
        end
        size_before = mq.size();
        if (popreq && head_ok) void'(mq.pop_front());
        if (push && size_before < 2) mq.push_back(pd);
        if (we && !m_run) sched[wa] = wd;
        if (m_run) begin
            if (run) m_pc = (m_pc == int'(sched_last)) ? 0 : (m_pc + 1) % 16;
            else begin m_run = 1'b0; m_pc = 0; end
        end else if (run) begin
            m_run = 1'b1;
            m_pc  = 0;
        end
        exp_q.push_back(e);
        cyc++;
    endtask

    // monitor: compares each registered output after the edge
    always @(posedge clk) begin
        exp_t          e;
        logic          av;
        logic [DW-1:0] ad;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            for (int k = 0; k < 5; k++) begin
                av = (k < 4) ? link_out_vld[k] : core_rx_vld;
                ad = (k < 4) ? link_out[k] : core_rx_data;
                check(av == e.vld[k] && ad == e.dat[k],
                      $sformatf("%s out%0d", e.tag, k),
                      {15'd0, av, ad}, {15'd0, e.vld[k], e.dat[k]});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) sched[i] = '0;
        rst_n = 1'b0;
        link_in = '0; link_in_vld = '0;
        core_tx_data = '0; core_tx_push = 1'b0;
        sched_run = 1'b0; sched_last = 4'd3;
        cfg_we = 1'b0; cfg_addr = '0; cfg_instr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(link_out_vld == 4'd0, "R1 link valid", {28'd0, link_out_vld}, 0);
        check(core_rx_vld == 1'b0, "R1 core valid", {31'd0, core_rx_vld}, 0);
        check(link_out == '0, "R1 link data", link_out[0], 0);
        check(core_rx_data == '0, "R1 core data", {16'd0, core_rx_data}, 0);
        check(core_tx_full == 1'b0, "R1 full", {31'd0, core_tx_full}, 0);
        rst_n = 1'b1;

        // load schedule while halted (R2 field layout, R4 multicast)
        step(0, 4'hF, 0, 0, 1, 4'd0, mk(X_I, X_N, X_N, X_I, X_W), "R6 R1");
        step(0, 4'hF, 0, 0, 1, 4'd1, mk(X_C, X_I, X_I, X_E, 3'd6), "R6");
        step(0, 4'hF, 0, 0, 1, 4'd2, mk(X_S, X_N, X_W, X_E, 3'd7), "R6");
        step(0, 4'hF, 0, 0, 1, 4'd3, mk(X_W, X_C, X_C, X_I, X_S), "R6");
        step(0, 4'hF, 0, 0, 1, 4'd4, mk(X_N, X_N, X_N, X_N, X_N), "R6");
        // fill core buffer, third push dropped
        step(0, 4'h0, 1, 16'hA001, 0, 0, 0, "R6 R8");
        step(0, 4'h0, 1, 16'hA002, 0, 0, 0, "R6 R8");
        @(posedge clk); #1;
        check(core_tx_full == 1'b1, "R8 full after two", {31'd0, core_tx_full}, 1);
        step(0, 4'h0, 1, 16'hA003, 0, 0, 0, "R6 R8");
        @(posedge clk); #1;
        check(core_tx_full == 1'b1, "R8 full after drop", {31'd0, core_tx_full}, 1);

        // run: slot order, wrap, multicast, core pops, empty pops, ignored write
        for (int i = 0; i < 15; i++)
            step(1, (i % 3 == 1) ? 4'b1011 : 4'b1111, (i >= 6 && i <= 8),
                 DW'(16'hC000 + i), (i == 9), 4'd0, mk(X_N, X_N, X_N, X_N, X_N),
                 "R2 R3 R4 R5 R7 R8 R9");
        for (int i = 0; i < 3; i++) step(0, 4'hF, 0, 0, 0, 0, 0, "R6");
        // second run: slot 0 must still hold the original setting
        for (int i = 0; i < 6; i++) step(1, 4'hF, 0, 0, 0, 0, 0, "R7 R6");
        for (int i = 0; i < 2; i++) step(0, 4'hF, 0, 0, 0, 0, 0, "R6");
        // shorter schedule
        @(negedge clk);
        sched_last = 4'd1;
        step(0, 4'hF, 1, 16'hB001, 0, 0, 0, "R6");
        for (int i = 0; i < 7; i++) step(1, (i == 2) ? 4'b0101 : 4'hF, 0, 0, 0, 0, 0, "R5 R9");
        for (int i = 0; i < 3; i++) step(0, 4'hF, 0, 0, 0, 0, 0, "R6");
        @(negedge clk);
        core_tx_push = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule